// File: doc/BRIEF.md
# Tuner Control Register Interface over I2C

This block is a two-wire serial slave that sits between a host controller and the digital part of a TV tuner. The host sends short telegrams: an address byte, then up to four data bytes. The slave sorts these bytes into a 15-bit divider ratio, a control byte, and a second byte that goes to either a band-switch register or an auxiliary register. A read telegram returns a status byte. The status byte carries a power-on flag, the loop lock flag and a 3-bit converter code. The slave keeps sending this byte for as long as the host acknowledges.

Both bus lines are oversampled on a system clock. Each line passes through a two-flop synchroniser and a persistence filter, so that short spikes never reach the protocol logic. SDA is open-drain: the block only drives an output-enable that pulls the line low. Any of four slave addresses can be chosen through a 2-bit select input. While a power-on event is present, the slave stays off the bus.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken on the rising SCL edge. A stop part-way through a byte abandons that telegram, and the next start opens a new one.
- R2: The slave acknowledges an address byte only when its upper seven bits equal ADDR_BASE with addr_sel_i placed in bits 1:0. Bit 0 of the address byte selects write (0) or read (1). For any other address the slave never pulls SDA low and changes no register.
- R3: A data byte in position 1 or 3 with bit 7 = 0 starts a divider pair. div_o becomes {first[6:0], second} only once the second byte of the pair has arrived. A telegram that stops after the first byte leaves div_o unchanged.
- R4: A data byte in position 1 or 3 with bit 7 = 1 is loaded as a whole into ctrl_o.
- R5: The byte after a control byte goes to aux_o when ctrl bits 5:3 equal 3'b011. Otherwise it goes to band_o.
- R6: Data bytes after the fourth are acknowledged and change no register.
- R7: On a read, the slave acknowledges the address and then sends the status byte MSB first. The status byte is bit 7 = power-on flag, bit 6 = lock_i, bits 5:3 = 0, bits 2:0 = adc_i. The slave sends the status byte again each time the host acknowledges, and releases SDA after a not-acknowledge.
- R8: The power-on flag is 1 after reset and after any cycle with por_evt_i high. It clears when the host not-acknowledges a status byte.
- R9: While por_evt_i is high, sda_oe_o is low and no telegram is accepted.
- R10: After reset, div_o, ctrl_o, band_o, aux_o and sda_oe_o are all zero.
- R11: A level on SCL or SDA that lasts fewer than FILT_LEN clocks has no effect on the protocol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| addr_sel_i | input | 2 | Chooses one of four slave addresses |
| adc_i | input | 3 | Converter code reported in status |
| lock_i | input | 1 | Loop lock flag reported in status |
| por_evt_i | input | 1 | Power-on or supply-drop event |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| div_o | output | DIV_HI_BITS+8 | Divider ratio |
| ctrl_o | output | 8 | Control byte |
| band_o | output | 8 | Band-switch byte |
| aux_o | output | 8 | Auxiliary byte |

## Verification
The bench builds the block with its default parameters: FILT_LEN = 4, ADDR_BASE = 7'h60, seven upper divider bits, and auxiliary code 3'b011. With a quarter bit period of eight clocks, a one-clock spike on SCL stays below the filter threshold, while real edges still reach the logic well inside each bit. The stimulus walks all four select codes, foreign addresses, telegrams of one to six bytes in every divider/control order, and multi-byte reads. It also exercises power-on events raised both between telegrams and during one.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_SKIP
   } bus_state_e;

   typedef enum logic {K_DIV, K_CTRL} byte_kind_e;

   localparam int BITS_PER_BYTE = 8;
   localparam int MAX_DATA_BYTES = 4;
endpackage

// File: rtl/tuner_line_filter.sv
module tuner_line_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int CW = $clog2(FILT_LEN + 1);

   if (FILT_LEN < 2) begin : g_bad_len
      $error("tuner_line_filter: FILT_LEN must be at least 2");
   end

   logic s1, s2;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1      <= 1'b1;
         s2      <= 1'b1;
         cnt     <= '0;
         clean_o <= 1'b1;
      end else begin
         s1 <= raw_i;
         s2 <= s1;
         if (s2 == clean_o) begin
            cnt <= '0;
         end else if (cnt == CW'(FILT_LEN - 1)) begin
            cnt     <= '0;
            clean_o <= s2;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R11
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_o != $past(clean_o)) |-> ($past(s2) == clean_o));
endmodule

// File: rtl/tuner_reg_file.sv
module tuner_reg_file
   import tuner_i2c_pkg::*;
#(
   parameter int         DIV_HI_BITS   = 7,
   parameter int         TEST_LSB      = 3,
   parameter logic [2:0] AUX_TEST_CODE = 3'b011
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_start_i,
   input  logic                   byte_stb_i,
   input  logic [7:0]             byte_i,
   input  logic                   por_evt_i,
   input  logic                   por_clr_i,
   input  logic                   lock_i,
   input  logic [2:0]             adc_i,
   output logic [DIV_HI_BITS+7:0] div_o,
   output logic [7:0]             ctrl_o,
   output logic [7:0]             band_o,
   output logic [7:0]             aux_o,
   output logic [7:0]             status_o
);
   localparam int IDX_W = $clog2(MAX_DATA_BYTES + 1);

   if (DIV_HI_BITS < 1 || DIV_HI_BITS > 7) begin : g_bad_div
      $error("tuner_reg_file: DIV_HI_BITS must be 1..7");
   end
   if (TEST_LSB < 0 || TEST_LSB > 4) begin : g_bad_test
      $error("tuner_reg_file: test field must fit below bit 7");
   end

   logic [IDX_W-1:0] idx;
   logic [7:0]       first_q;
   byte_kind_e       kind_q;
   logic             por_q;
   logic             take;

   assign take = byte_stb_i && (idx < IDX_W'(MAX_DATA_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         first_q <= '0;
         kind_q  <= K_DIV;
         div_o   <= '0;
         ctrl_o  <= '0;
         band_o  <= '0;
         aux_o   <= '0;
      end else if (frame_start_i) begin
         idx <= '0;
      end else if (take) begin
         idx <= idx + 1'b1;
         if (!idx[0]) begin
            first_q <= byte_i;
            kind_q  <= byte_i[7] ? K_CTRL : K_DIV;
            if (byte_i[7]) ctrl_o <= byte_i;
         end else if (kind_q == K_DIV) begin
            div_o <= {first_q[DIV_HI_BITS-1:0], byte_i};
         end else if (ctrl_o[TEST_LSB +: 3] == AUX_TEST_CODE) begin
            aux_o <= byte_i;
         end else begin
            band_o <= byte_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         por_q <= 1'b1;
      else if (por_evt_i) por_q <= 1'b1;
      else if (por_clr_i) por_q <= 1'b0;
   end

   assign status_o = {por_q, lock_i, 3'b000, adc_i};

   // R3
   div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_o) |-> $past(byte_stb_i && idx[0]));
   // R8
   por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(por_q) |-> $past(por_evt_i));
   // R6
   idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IDX_W'(MAX_DATA_BYTES));
endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
   import tuner_i2c_pkg::*;
#(
   parameter int         FILT_LEN      = 4,
   parameter logic [6:0] ADDR_BASE     = 7'h60,
   parameter int         DIV_HI_BITS   = 7,
   parameter int         TEST_LSB      = 3,
   parameter logic [2:0] AUX_TEST_CODE = 3'b011
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   input  logic [1:0]             addr_sel_i,
   input  logic [2:0]             adc_i,
   input  logic                   lock_i,
   input  logic                   por_evt_i,
   output logic                   sda_oe_o,
   output logic [DIV_HI_BITS+7:0] div_o,
   output logic [7:0]             ctrl_o,
   output logic [7:0]             band_o,
   output logic [7:0]             aux_o
);
   localparam int NLINES = 2;
   localparam int BIT_CW = $clog2(BITS_PER_BYTE + 1);
   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BITS_PER_BYTE);

   if (ADDR_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("tuner_i2c_ctrl: ADDR_BASE bits 1:0 must be zero");
   end

   logic [NLINES-1:0] raw, clean;
   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      tuner_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
         .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .clean_o(clean[g]));
   end

   logic scl_f, sda_f, scl_d, sda_d;
   assign scl_f = clean[1];
   assign sda_f = clean[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   logic scl_rise, scl_fall, start_c, stop_c;
   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

   bus_state_e        st;
   logic [BIT_CW-1:0] bitcnt;
   logic [7:0]        sh, tx, status;
   logic              oe_q, rw_q, mack;
   logic              addr_hit, byte_stb, frame_start, por_clr;

   assign addr_hit    = (sh[7:1] == (ADDR_BASE | {5'b0, addr_sel_i}));
   assign byte_stb    = (st == S_WR) && scl_fall && (bitcnt == LAST_BIT) && !por_evt_i;
   assign frame_start = (st == S_AACK) && scl_fall && !rw_q && !por_evt_i;
   assign por_clr     = (st == S_RACK) && scl_fall && !mack && !por_evt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; oe_q <= 1'b0; bitcnt <= '0;
         sh <= '0; tx <= '0; rw_q <= 1'b0; mack <= 1'b0;
      end else if (por_evt_i || stop_c) begin
         st <= S_IDLE; oe_q <= 1'b0;
      end else if (start_c) begin
         st <= S_ADDR; oe_q <= 1'b0; bitcnt <= '0;
      end else begin
         unique case (st)
            S_ADDR, S_WR: begin
               if (scl_rise) begin
                  sh     <= {sh[6:0], sda_f};
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall && bitcnt == LAST_BIT) begin
                  if (st == S_WR) begin
                     st <= S_WACK; oe_q <= 1'b1;
                  end else if (addr_hit) begin
                     st <= S_AACK; oe_q <= 1'b1; rw_q <= sh[0];
                  end else begin
                     st <= S_SKIP;
                  end
               end
            end
            S_AACK, S_WACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (st == S_AACK && rw_q) begin
                     st <= S_RD; tx <= status; oe_q <= ~status[7];
                  end else begin
                     st <= S_WR; oe_q <= 1'b0;
                  end
               end
            end
            S_RD: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall) begin
                  if (bitcnt == LAST_BIT) begin
                     st <= S_RACK; oe_q <= 1'b0;
                  end else begin
                     tx <= {tx[6:0], 1'b0}; oe_q <= ~tx[6];
                  end
               end
            end
            S_RACK: begin
               if (scl_rise) begin
                  mack <= ~sda_f;
               end else if (scl_fall) begin
                  if (mack) begin
                     st <= S_RD; tx <= status; oe_q <= ~status[7]; bitcnt <= '0;
                  end else begin
                     st <= S_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q & ~por_evt_i;

   tuner_reg_file #(
      .DIV_HI_BITS(DIV_HI_BITS), .TEST_LSB(TEST_LSB), .AUX_TEST_CODE(AUX_TEST_CODE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .byte_stb_i(byte_stb),
      .byte_i(sh), .por_evt_i(por_evt_i), .por_clr_i(por_clr), .lock_i(lock_i),
      .adc_i(adc_i), .div_o(div_o), .ctrl_o(ctrl_o), .band_o(band_o), .aux_o(aux_o),
      .status_o(status));

   // R2
   ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_o |-> (st inside {S_AACK, S_WACK, S_RD}));
   // R9
   por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(por_evt_i) |-> (st == S_IDLE && !oe_q));
   // R7
   rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RD && scl_f && $past(scl_f) && $past(st) == S_RD) |-> $stable(oe_q));
endmodule

// File: tb/tuner_i2c_ctrl_tb.sv
module tuner_i2c_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;
   localparam logic [6:0] BASE = 7'h60;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] addr_sel = 2'd0;
   logic [2:0] adc = 3'd0;
   logic lock = 1'b0, por_evt = 1'b0;
   logic sda_oe;
   logic [14:0] div;
   logic [7:0] ctrl, band, aux;
   logic bus;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign bus = sda_m & ~sda_oe;

   tuner_i2c_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus), .addr_sel_i(addr_sel),
      .adc_i(adc), .lock_i(lock), .por_evt_i(por_evt), .sda_oe_o(sda_oe),
      .div_o(div), .ctrl_o(ctrl), .band_o(band), .aux_o(aux));

   int n_vec = 0, n_bad = 0, por_viol = 0;
   logic [14:0] e_div = '0;
   logic [7:0] e_ctrl = '0, e_band = '0, e_aux = '0;
   logic e_por = 1'b1;
   logic [7:0] tbuf [0:7];
   bit glitch = 1'b0;

   always @(negedge clk) if (por_evt && sda_oe) por_viol++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic w(int n); repeat (n) @(negedge clk); endtask

   task automatic i2c_start();
      sda_m = 1'b1; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b0; w(2*Q); scl_m = 1'b0;
   endtask

   task automatic i2c_stop();
      w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b1; w(2*Q);
   endtask

   task automatic mbit(logic b);
      w(Q); sda_m = b; w(Q); scl_m = 1'b1; w(Q);
      if (glitch) begin scl_m = 1'b0; w(1); scl_m = 1'b1; w(Q-1); end
      else w(Q);
      scl_m = 1'b0;
   endtask

   task automatic sbit(output logic b);
      sda_m = 1'b1; w(2*Q); scl_m = 1'b1; w(Q); b = bus; w(Q); scl_m = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] b, output logic ack);
      logic v;
      for (int i = 7; i >= 0; i--) mbit(b[i]);
      sbit(v); ack = ~v;
   endtask

   function automatic logic [7:0] exp_status();
      return {e_por, lock, 3'b000, adc};
   endfunction

   // Reference model of one accepted write telegram (R3, R4, R5, R6)
   task automatic model_write(int n);
      logic [7:0] first = '0;
      logic is_ctrl = 1'b0;
      for (int i = 0; i < n && i < 4; i++) begin
         if (i % 2 == 0) begin
            first = tbuf[i]; is_ctrl = tbuf[i][7];
            if (is_ctrl) e_ctrl = tbuf[i];
         end else if (!is_ctrl) e_div = {first[6:0], tbuf[i]};
         else if (e_ctrl[5:3] == 3'b011) e_aux = tbuf[i];
         else e_band = tbuf[i];
      end
   endtask

   task automatic write_tel(logic [6:0] a7, int n, string req);
      logic ack; int acks = 0; bit hit;
      hit = (a7 == (BASE | {5'b0, addr_sel})) && !por_evt;
      i2c_start();
      send_byte({a7, 1'b0}, ack);
      if (ack) begin
         acks++;
         for (int i = 0; i < n; i++) begin send_byte(tbuf[i], ack); if (ack) acks++; end
      end
      i2c_stop();
      if (hit) model_write(n);
      chk({req, " R2 ack count"}, acks, hit ? n + 1 : 0);
      chk({req, " R3 div"}, div, e_div);
      chk({req, " R4 ctrl"}, ctrl, e_ctrl);
      chk({req, " R5 band"}, band, e_band);
      chk({req, " R5 aux"}, aux, e_aux);
   endtask

   task automatic read_tel(logic [6:0] a7, int nb, string req);
      logic ack, v; logic [7:0] got; bit hit;
      hit = (a7 == (BASE | {5'b0, addr_sel}));
      i2c_start();
      send_byte({a7, 1'b1}, ack);
      chk({req, " R2 read addr ack"}, ack, hit);
      if (ack) begin
         for (int k = 0; k < nb; k++) begin
            for (int i = 7; i >= 0; i--) begin sbit(v); got[i] = v; end
            chk({req, " R7 status byte"}, got, exp_status());
            mbit(k == nb - 1);
         end
         e_por = 1'b0;
      end
      i2c_stop();
      chk({req, " R7 released"}, sda_oe, 0);
   endtask

   initial begin : watchdog
      repeat (180000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog all-reqs act=timeout exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = $urandom(32'd4242);
      w(5); rst_n = 1'b1; w(4);
      // R10 reset state
      chk("R10 div", div, 0); chk("R10 ctrl", ctrl, 0); chk("R10 band", band, 0);
      chk("R10 aux", aux, 0); chk("R10 sda_oe", sda_oe, 0);

      // R7 R8 status repeats with POR set, then POR clears after not-ack
      lock = 1'b1; adc = 3'd5;
      read_tel(BASE, 2, "R8 por after reset");
      read_tel(BASE, 1, "R8 por cleared");

      // R3 divider pair
      tbuf[0] = 8'h12; tbuf[1] = 8'h34; write_tel(BASE, 2, "R3 div pair");
      tbuf[0] = 8'h55; write_tel(BASE, 1, "R3 lone first byte");
      // R4 R5 control then band, then control selecting aux
      tbuf[0] = 8'h80; tbuf[1] = 8'h41; write_tel(BASE, 2, "R5 band");
      tbuf[0] = 8'h98; tbuf[1] = 8'h5A; write_tel(BASE, 2, "R5 aux");
      // R6 extra bytes after the fourth are ignored
      tbuf[0] = 8'h0F; tbuf[1] = 8'hF0; tbuf[2] = 8'hC1; tbuf[3] = 8'h22;
      tbuf[4] = 8'h7E; tbuf[5] = 8'hE7; write_tel(BASE, 6, "R6 overflow");
      // R2 every select code, and a foreign address
      for (int s = 0; s < 4; s++) begin
         addr_sel = 2'(s);
         tbuf[0] = 8'(s); tbuf[1] = 8'(8'hA0 + s); write_tel(BASE | 7'(s), 2, "R2 sel");
      end
      addr_sel = 2'd1;
      tbuf[0] = 8'h01; tbuf[1] = 8'h01; write_tel(BASE | 7'd2, 2, "R2 foreign");
      // R1 telegram abandoned by a stop mid-byte, then a fresh one
      i2c_start(); mbit(1); mbit(1); mbit(0); i2c_stop();
      tbuf[0] = 8'h23; tbuf[1] = 8'h45; write_tel(BASE | 7'd1, 2, "R1 restart");
      // R11 one-clock spikes on SCL
      glitch = 1'b1; tbuf[0] = 8'h3C; tbuf[1] = 8'hC3; write_tel(BASE | 7'd1, 2, "R11 glitch");
      glitch = 1'b0;
      // R8 R9 power-on event during a telegram
      por_evt = 1'b1; e_por = 1'b1;
      tbuf[0] = 8'h77; tbuf[1] = 8'h77; write_tel(BASE | 7'd1, 2, "R9 por held");
      por_evt = 1'b0; w(2);
      chk("R9 sda_oe during por", por_viol, 0);
      lock = 1'b0; adc = 3'd2;
      read_tel(BASE | 7'd1, 3, "R8 por event");

      // constrained random telegrams
      for (int t = 0; t < 24; t++) begin
         logic [6:0] a7; int n;
         addr_sel = 2'($urandom % 4);
         a7 = BASE | {5'b0, addr_sel};
         if ($urandom % 6 == 0) a7 = BASE | {5'b0, 2'(addr_sel + 2'(1 + $urandom % 3))};
         lock = 1'($urandom); adc = 3'($urandom);
         if ($urandom % 4 == 0) begin
            read_tel(a7, 1 + $urandom % 3, "R7 random read");
         end else begin
            n = 1 + $urandom % 5;
            for (int i = 0; i < 8; i++) tbuf[i] = 8'($urandom);
            write_tel(a7, n, "R3 random write");
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule